// File: doc/BRIEF.md
# 8-bit ALU and Status Flags

This block is the arithmetic-logic unit of a small 8-bit processor core, together with the processor status byte. Each cycle the decoder presents an operation code, the register value (accumulator or index register), a memory or immediate operand and a bit number. The unit returns the result byte combinationally, from those inputs and the stored carry. When `op_valid` is high, the clock edge writes the new flags into the status byte. Each operation writes only the flags its own rule names. Every other flag keeps its value.

The operations are add and subtract with carry, and compare. There are AND, OR, XOR and a pass-through load. There are shift left, shift right and the two rotates through carry, plus increment and decrement. There is a bit test in two forms: with a memory operand and with an immediate operand. There are test-and-clear-bits and test-and-set-bits, clear or set of one numbered bit, and the single-flag set and clear operations. Decimal correction is not performed. The D flag is only stored.

The block has no state machine. The only state is the status register, reset to a fixed value and then loaded through a per-flag write mask.

Top module: `alu8_unit`

## Requirements
- R1: After reset `status_o` is 0x24. The flag positions are N=bit 7, V=bit 6, bit 5 always 1, bit 4 always 0, D=bit 3, I=bit 2, Z=bit 1, C=bit 0.
- R2: Add-with-carry (code 0) gives acc+opnd+C. Subtract-with-carry (code 1) gives acc-opnd-(1-C). Both write N, Z, V (signed overflow) and C. After a subtract, C=1 means no borrow.
- R3: Compare (code 2) writes N and Z from acc-opnd and sets C=1 when acc>=opnd (unsigned). V is left unchanged and `result_o` equals `acc_in`.
- R4: AND (3), OR (4), XOR (5) and load (6, which returns opnd) write only N and Z from the result.
- R5: Shift left (7) moves opnd bit 7 into C and a 0 into bit 0. Shift right (8) moves bit 0 into C and a 0 into bit 7, so N becomes 0. Both also write Z.
- R6: Rotate left (9) and rotate right (10) move C into the vacated end and the bit shifted out into C. They write N, Z and C.
- R7: Increment (11) and decrement (12) of opnd wrap modulo 256 and write only N and Z.
- R8: Bit test (13) sets Z when acc&opnd is 0 and copies opnd bits 7 and 6 into N and V. The immediate bit test (14) writes only Z. Both return acc.
- R9: Test-and-clear (15) returns ~acc&opnd and test-and-set (16) returns acc|opnd. Both set Z from acc&opnd and leave N, V and C unchanged.
- R10: Bit clear (17) and bit set (18) clear or set opnd bit `bit_sel` (0 to 7) and change no flag.
- R11: Codes 19 to 25 clear C, set C, clear D, set D, clear I, set I and clear V, one flag each. They return acc.
- R12: When `op_valid` is low, or for the unused codes 26 to 31, the status byte does not change. The unused codes also return acc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Commit flags of this cycle's operation |
| op_sel | input | 5 | Operation code |
| acc_in | input | 8 | Register operand (accumulator or index) |
| opnd_in | input | 8 | Memory or immediate operand |
| bit_sel | input | 3 | Bit number for single-bit clear/set |
| result_o | output | 8 | Result byte (combinational) |
| status_o | output | 8 | Status byte |

## Verification
The add and subtract paths are driven with operand pairs that overflow in the signed sense only, in the unsigned sense only, in both senses and in neither. These pairs tell the V and C rules apart, and they also show whether the carry-in is used. Compare is tried with equal, greater and smaller values, which exposes an inverted borrow. The shifts and rotates are run with both carry values and with the edge bits set. Each flag-preserving operation is run after a flag-setting one, so that a wrong write mask shows up as a changed flag. A long random sequence that includes idle cycles and unused codes is compared each clock against a behavioural model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD_C     = 5'd0,
        OP_SUB_C     = 5'd1,
        OP_CMP       = 5'd2,
        OP_AND       = 5'd3,
        OP_OR        = 5'd4,
        OP_XOR       = 5'd5,
        OP_PASS      = 5'd6,
        OP_SHL       = 5'd7,
        OP_SHR       = 5'd8,
        OP_ROTL      = 5'd9,
        OP_ROTR      = 5'd10,
        OP_INC       = 5'd11,
        OP_DEC       = 5'd12,
        OP_BTEST     = 5'd13,
        OP_BTEST_IMM = 5'd14,
        OP_TCLR      = 5'd15,
        OP_TSET      = 5'd16,
        OP_BCLR      = 5'd17,
        OP_BSET      = 5'd18,
        OP_CLR_C     = 5'd19,
        OP_SET_C     = 5'd20,
        OP_CLR_D     = 5'd21,
        OP_SET_D     = 5'd22,
        OP_CLR_I     = 5'd23,
        OP_SET_I     = 5'd24,
        OP_CLR_V     = 5'd25
    } alu_op_e;

    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_I = 2;
    localparam int FLG_D = 3;
    localparam int FLG_B = 4;
    localparam int FLG_1 = 5;
    localparam int FLG_V = 6;
    localparam int FLG_N = 7;

    localparam int STATUS_W = 8;

endpackage

// File: rtl/alu8_datapath.sv
module alu8_datapath
    import alu8_pkg::*;
#(
    parameter int DW = 8,
    parameter int BW = $clog2(DW)
) (
    input  alu_op_e              op,
    input  logic [DW-1:0]        a,
    input  logic [DW-1:0]        s,
    input  logic [BW-1:0]        bsel,
    input  logic                 c_in,
    output logic [DW-1:0]        res,
    output logic [STATUS_W-1:0]  cand
);
    localparam int MSB = DW - 1;

    logic          is_sub;
    logic [DW-1:0] addend;
    logic          add_cin;
    logic [DW:0]   sum;
    logic          ovf;
    logic [DW-1:0] and_as;
    logic [DW-1:0] onehot;

    // one adder serves add, subtract and compare
    always_comb begin
        is_sub  = (op == OP_SUB_C) || (op == OP_CMP);
        addend  = is_sub ? ~s : s;
        add_cin = (op == OP_CMP) ? 1'b1 : c_in;
        sum     = {1'b0, a} + {1'b0, addend} + {{DW{1'b0}}, add_cin};
        ovf     = (a[MSB] == addend[MSB]) && (sum[MSB] != a[MSB]);
        and_as  = a & s;
        onehot  = {{(DW-1){1'b0}}, 1'b1} << bsel;
    end

    always_comb begin
        res  = a;
        cand = '0;
        unique case (op)
            OP_ADD_C, OP_SUB_C: begin
                res         = sum[MSB:0];
                cand[FLG_C] = sum[DW];
                cand[FLG_V] = ovf;
            end
            OP_CMP: begin
                res         = a;
                cand[FLG_C] = sum[DW];
            end
            OP_AND:  res = and_as;
            OP_OR:   res = a | s;
            OP_XOR:  res = a ^ s;
            OP_PASS: res = s;
            OP_SHL: begin
                res         = {s[MSB-1:0], 1'b0};
                cand[FLG_C] = s[MSB];
            end
            OP_SHR: begin
                res         = {1'b0, s[MSB:1]};
                cand[FLG_C] = s[0];
            end
            OP_ROTL: begin
                res         = {s[MSB-1:0], c_in};
                cand[FLG_C] = s[MSB];
            end
            OP_ROTR: begin
                res         = {c_in, s[MSB:1]};
                cand[FLG_C] = s[0];
            end
            OP_INC:  res = s + 1'b1;
            OP_DEC:  res = s - 1'b1;
            OP_BTEST, OP_BTEST_IMM: begin
                res         = a;
                cand[FLG_V] = s[MSB-1];
            end
            OP_TCLR: res = ~a & s;
            OP_TSET: res = a | s;
            OP_BCLR: res = s & ~onehot;
            OP_BSET: res = s | onehot;
            OP_SET_C: cand[FLG_C] = 1'b1;
            OP_SET_D: cand[FLG_D] = 1'b1;
            OP_SET_I: cand[FLG_I] = 1'b1;
            default: res = a;
        endcase

        // N and Z sources differ for the bit-test family
        case (op)
            OP_CMP: begin
                cand[FLG_N] = sum[MSB];
                cand[FLG_Z] = (sum[MSB:0] == '0);
            end
            OP_BTEST, OP_BTEST_IMM, OP_TCLR, OP_TSET: begin
                cand[FLG_N] = s[MSB];
                cand[FLG_Z] = (and_as == '0);
            end
            default: begin
                cand[FLG_N] = res[MSB];
                cand[FLG_Z] = (res == '0);
            end
        endcase
    end

endmodule

// File: rtl/alu8_flagmask.sv
module alu8_flagmask
    import alu8_pkg::*;
(
    input  alu_op_e              op,
    output logic [STATUS_W-1:0]  wmask
);
    localparam logic [STATUS_W-1:0] M_N = STATUS_W'(1) << FLG_N;
    localparam logic [STATUS_W-1:0] M_V = STATUS_W'(1) << FLG_V;
    localparam logic [STATUS_W-1:0] M_D = STATUS_W'(1) << FLG_D;
    localparam logic [STATUS_W-1:0] M_I = STATUS_W'(1) << FLG_I;
    localparam logic [STATUS_W-1:0] M_Z = STATUS_W'(1) << FLG_Z;
    localparam logic [STATUS_W-1:0] M_C = STATUS_W'(1) << FLG_C;

    always_comb begin
        unique case (op)
            OP_ADD_C, OP_SUB_C:                      wmask = M_N | M_V | M_Z | M_C;
            OP_CMP, OP_SHL, OP_SHR, OP_ROTL, OP_ROTR: wmask = M_N | M_Z | M_C;
            OP_AND, OP_OR, OP_XOR, OP_PASS,
            OP_INC, OP_DEC:                          wmask = M_N | M_Z;
            OP_BTEST:                                wmask = M_N | M_V | M_Z;
            OP_BTEST_IMM, OP_TCLR, OP_TSET:          wmask = M_Z;
            OP_CLR_C, OP_SET_C:                      wmask = M_C;
            OP_CLR_D, OP_SET_D:                      wmask = M_D;
            OP_CLR_I, OP_SET_I:                      wmask = M_I;
            OP_CLR_V:                                wmask = M_V;
            default:                                 wmask = '0;
        endcase
    end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu8_pkg::*;
#(
    parameter logic [STATUS_W-1:0] RST_VAL = 8'h24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [STATUS_W-1:0]  wmask,
    input  logic [STATUS_W-1:0]  cand,
    output logic [STATUS_W-1:0]  p_q
);
    logic [STATUS_W-1:0] p_r;
    logic [STATUS_W-1:0] p_nx;

    genvar gi;
    generate
        for (gi = 0; gi < STATUS_W; gi++) begin : g_bit
            if (gi == FLG_1) begin : g_one
                assign p_nx[gi] = 1'b1;
            end else if (gi == FLG_B) begin : g_zero
                assign p_nx[gi] = 1'b0;
            end else begin : g_flag
                assign p_nx[gi] = (wr_en && wmask[gi]) ? cand[gi] : p_r[gi];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_r <= RST_VAL;
        end else begin
            p_r <= p_nx;
        end
    end

    assign p_q = p_r;

endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
    import alu8_pkg::*;
#(
    parameter int DW = 8,
    parameter int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [4:0]    op_sel,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] opnd_in,
    input  logic [BW-1:0] bit_sel,
    output logic [DW-1:0] result_o,
    output logic [7:0]    status_o
);
    alu_op_e             op_e;
    logic [STATUS_W-1:0] cand;
    logic [STATUS_W-1:0] wmask;
    logic [STATUS_W-1:0] p_q;

    assign op_e = alu_op_e'(op_sel);

    alu8_datapath #(.DW(DW), .BW(BW)) u_dp (
        .op   (op_e),
        .a    (acc_in),
        .s    (opnd_in),
        .bsel (bit_sel),
        .c_in (p_q[FLG_C]),
        .res  (result_o),
        .cand (cand)
    );

    alu8_flagmask u_mask (
        .op    (op_e),
        .wmask (wmask)
    );

    alu8_status #(.RST_VAL(8'h24)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (op_valid),
        .wmask (wmask),
        .cand  (cand),
        .p_q   (p_q)
    );

    assign status_o = p_q;

endmodule

// File: rtl/alu8_unit_chk.sv
module alu8_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [4:0] op_sel,
    input logic [7:0] acc_in,
    input logic [7:0] result_o,
    input logic [7:0] status_o
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(status_o)); // R12

    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 5'd2) |-> (result_o == acc_in)); // R3

    AST_LOGIC_Z: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel >= 5'd3 && op_sel <= 5'd6)
        |=> (status_o[1] == ($past(result_o) == 8'h00))); // R4

    AST_SHR_N_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 5'd8) |=> !status_o[7]); // R5

    AST_INCDEC_VC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == 5'd11 || op_sel == 5'd12))
        |=> (status_o[6] == $past(status_o[6]) && status_o[0] == $past(status_o[0]))); // R7

    AST_TEST_BITS_NVC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == 5'd15 || op_sel == 5'd16))
        |=> (status_o[7] == $past(status_o[7]) && status_o[6] == $past(status_o[6])
             && status_o[0] == $past(status_o[0]))); // R9

    AST_BITOP_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == 5'd17 || op_sel == 5'd18)) |=> $stable(status_o)); // R10

    AST_SET_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 5'd20) |=> status_o[0]); // R11

endmodule

bind alu8_unit alu8_unit_chk u_chk (.*);

// File: tb/alu8_unit_test.sv
`timescale 1ns/1ps
module alu8_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic [2:0] bit_sel = '0;
    logic [7:0] result_o;
    logic [7:0] status_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] mp;
    bit done = 0;

    always #2.5 clk = ~clk;

    alu8_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .acc_in(acc_in), .opnd_in(opnd_in), .bit_sel(bit_sel),
        .result_o(result_o), .status_o(status_o)
    );

    function automatic string tag_of(input int op);
        if (op <= 1) return "R2";
        if (op == 2) return "R3";
        if (op <= 6) return "R4";
        if (op <= 8) return "R5";
        if (op <= 10) return "R6";
        if (op <= 12) return "R7";
        if (op <= 14) return "R8";
        if (op <= 16) return "R9";
        if (op <= 18) return "R10";
        if (op <= 25) return "R11";
        return "R12";
    endfunction

    function automatic void model(input int op, input logic [7:0] a, input logic [7:0] s,
                                  input logic [2:0] b, input logic [7:0] pin,
                                  output logic [7:0] r, output logic [7:0] po);
        int t, sv, cy;
        bit nz;
        po = pin; r = a; nz = 0;
        cy = int'(pin[0]);
        case (op)
            0: begin
                t = int'(a) + int'(s) + cy; r = t[7:0]; po[0] = (t > 255);
                sv = int'($signed(a)) + int'($signed(s)) + cy;
                po[6] = (sv > 127 || sv < -128); nz = 1;
            end
            1: begin
                t = int'(a) - int'(s) - (1 - cy); r = t[7:0]; po[0] = (t >= 0);
                sv = int'($signed(a)) - int'($signed(s)) - (1 - cy);
                po[6] = (sv > 127 || sv < -128); nz = 1;
            end
            2: begin
                t = int'(a) - int'(s); po[0] = (a >= s); po[7] = t[7]; po[1] = (a == s);
            end
            3: begin r = a & s; nz = 1; end
            4: begin r = a | s; nz = 1; end
            5: begin r = a ^ s; nz = 1; end
            6: begin r = s; nz = 1; end
            7: begin r = s << 1; po[0] = s[7]; nz = 1; end
            8: begin r = s >> 1; po[0] = s[0]; nz = 1; end
            9: begin r = {s[6:0], pin[0]}; po[0] = s[7]; nz = 1; end
            10: begin r = {pin[0], s[7:1]}; po[0] = s[0]; nz = 1; end
            11: begin r = s + 8'd1; nz = 1; end
            12: begin r = s - 8'd1; nz = 1; end
            13: begin po[1] = ((a & s) == 0); po[7] = s[7]; po[6] = s[6]; end
            14: po[1] = ((a & s) == 0);
            15: begin r = ~a & s; po[1] = ((a & s) == 0); end
            16: begin r = a | s; po[1] = ((a & s) == 0); end
            17: begin r = s; r[b] = 1'b0; end
            18: begin r = s; r[b] = 1'b1; end
            19: po[0] = 0;
            20: po[0] = 1;
            21: po[3] = 0;
            22: po[3] = 1;
            23: po[2] = 0;
            24: po[2] = 1;
            25: po[6] = 0;
            default: ;
        endcase
        if (nz) begin po[7] = r[7]; po[1] = (r == 0); end
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag,
                         input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic step(input int op, input logic [7:0] a, input logic [7:0] s,
                        input logic [2:0] b, input bit v);
        logic [7:0] er, ep;
        @(negedge clk);
        op_valid = v; op_sel = op[4:0]; acc_in = a; opnd_in = s; bit_sel = b;
        model(op, a, s, b, mp, er, ep);
        if (!v) ep = mp;
        #1;
        check(result_o, er, tag_of(op), "result");
        @(posedge clk);
        #1;
        check(status_o, ep, v ? tag_of(op) : "R12", "status");
        mp = ep;
    endtask

    initial begin
        #(5.0 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check(status_o, 8'h24, "R1", "reset status");
        mp = 8'h24;
        // R2: signed-only, unsigned-only, both, carry-in
        step(19, 0, 0, 0, 1);
        step(0, 8'h50, 8'h50, 0, 1);
        step(0, 8'hFF, 8'h01, 0, 1);
        step(0, 8'h80, 8'h80, 0, 1);
        step(0, 8'h10, 8'h10, 0, 1);
        step(20, 0, 0, 0, 1);
        step(1, 8'h50, 8'hB0, 0, 1);
        step(1, 8'h00, 8'h01, 0, 1);
        // R3: equal, greater, smaller
        step(2, 8'h42, 8'h42, 0, 1);
        step(2, 8'h43, 8'h42, 0, 1);
        step(2, 8'h01, 8'hF0, 0, 1);
        // R4
        step(3, 8'hF0, 8'h0F, 0, 1);
        step(6, 8'h00, 8'h80, 0, 1);
        // R5, R6
        step(8, 0, 8'h01, 0, 1);
        step(7, 0, 8'h80, 0, 1);
        step(9, 0, 8'h80, 0, 1);
        step(10, 0, 8'h01, 0, 1);
        // R7: wrap both ways
        step(11, 0, 8'hFF, 0, 1);
        step(12, 0, 8'h00, 0, 1);
        // R8
        step(13, 8'h00, 8'hC0, 0, 1);
        step(14, 8'h01, 8'h3F, 0, 1);
        // R9
        step(20, 0, 0, 0, 1);
        step(15, 8'h0F, 8'hFF, 0, 1);
        step(16, 8'hF0, 8'h0F, 0, 1);
        // R10
        step(18, 0, 8'h00, 3'd7, 1);
        step(17, 0, 8'hFF, 3'd0, 1);
        // R11
        step(22, 0, 0, 0, 1);
        step(23, 0, 0, 0, 1);
        step(25, 0, 0, 0, 1);
        // R12
        step(19, 8'h11, 0, 0, 0);
        step(30, 8'h5A, 8'hA5, 0, 1);
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 31), 8'($urandom), 8'($urandom), 3'($urandom),
                 ($urandom_range(0, 7) != 0));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule